// File: doc/BRIEF.md
# VBI Slice RAM Packer

This block sits between a vertical-blanking-interval data slicer and a 16-bit-wide slice RAM. For each sliced line it first writes an identification word at the head address of the line's region. That word records which line-match register fired and which field the line belongs to. The received payload bytes then go to consecutive addresses starting 0x20 words above the head.

Two packing schemes are selected per line. In the byte-pair scheme, two received bytes share one 16-bit word. In the bi-phase scheme, each word carries one decoded byte in its lower half and one validity warning per data bit in its upper half. The decoded byte and the warnings both come from raw symbol pairs.

A start control gates all storage. At most one RAM write is issued per clock. When a byte arrives in the same cycle as the header write, the byte is held and written one cycle later.

Top module: `vbi_slice_packer`

## Requirements
- R1: No RAM write occurs while `start` is 0. Line starts, bytes and line ends presented while `start` is 0 are ignored and produce no writes.
- R2: With `fmt_sel`=0 (byte-pair scheme), every two accepted bytes form one word. The earlier byte goes in bits 7:0 and the later byte in bits 15:8.
- R3: In the byte-pair scheme, a line that ends with an odd byte count gets a final word when the line ends. That word holds the leftover byte in bits 7:0 and zero in bits 15:8.
- R4: With `fmt_sel`=1 (bi-phase scheme), each byte fills one word. Symbol pair n of a byte occupies `sym_in[2n+1:2n]`, its first symbol is `sym_in[2n+1]`, and data bit n is that first symbol, whether or not the pair is valid.
- R5: In the bi-phase scheme, word bit n+8 is the warning for data bit n. It is 1 when the two symbols of pair n are equal (00 or 11) and 0 when they differ.
- R6: One cycle after an accepted line start, a header word is written at `base_addr`. Its bits 1:0 are a priority code of `line_hit`: 11 if bit 2 is set, else 10 if bit 1 is set, else 01 if bit 0 is set, else 00.
- R7: Header bit 3 equals `field_first`, which is 1 for the first field. Header bit 2 and bits 15:4 are zero.
- R8: Payload word k of a line is written at `base_addr` + 0x20 + k, with k counting from 0.
- R9: At most 21 payload words per line are written in the byte-pair scheme and 13 in the bi-phase scheme. Further bytes write nothing, so the address after the last payload word stays unwritten.
- R10: The scheme is taken from `fmt_sel` at the line start. A change of `fmt_sel` during the line has no effect until the next line.
- R11: There is at most one write per cycle. A write appears on the port in the cycle after the edge that accepted its event. A byte accepted during the header's cycle is written exactly one cycle after the header.
- R12: A synchronous active-high `rst` drives `wr_en` low and `wr_addr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Storage enable |
| fmt_sel | input | 1 | Packing scheme: 0 byte-pair, 1 bi-phase |
| line_start | input | 1 | Begin-of-line strobe |
| line_end | input | 1 | End-of-line strobe |
| line_hit | input | 3 | Match flags for line registers 1..3 (bit 0..2) |
| field_first | input | 1 | 1 for the first field, 0 for the second |
| base_addr | input | AW | Region head address for the line |
| byte_vld | input | 1 | Received byte strobe |
| byte_in | input | 8 | Received byte (byte-pair scheme) |
| sym_in | input | 16 | Raw symbol pairs (bi-phase scheme) |
| wr_en | output | 1 | RAM write enable |
| wr_addr | output | AW | RAM write address |
| wr_data | output | 16 | RAM write data |

## Verification
The bench aims at the odd-length byte-pair line. A design that dropped the tail, or kept stale upper bits in it, would leave a wrong or missing last word. It also drives lines longer than each scheme's word limit, where a missing bound would overwrite the word after the payload. Bi-phase bytes include all-valid, all-invalid and mixed pairs, which catch a warning bit placed on the wrong position or inverted. The bench also checks a byte that collides with the header, where a design without the hold would lose the byte or issue two writes in one cycle. A mid-line format flip catches a design that reads `fmt_sel` live instead of latching it, and every header is checked for priority order and field-bit placement.

// File: rtl/vbi_pack_pkg.sv
package vbi_pack_pkg;

  typedef enum logic {
    FMT_PAIR = 1'b0,
    FMT_BIPH = 1'b1
  } pack_fmt_e;

  // Priority code of the line-register match flags, highest register wins.
  function automatic logic [1:0] src_code(input logic [2:0] hit);
    if (hit[2])      return 2'b11;
    else if (hit[1]) return 2'b10;
    else if (hit[0]) return 2'b01;
    else             return 2'b00;
  endfunction

  function automatic logic [15:0] hdr_word(input logic [2:0] hit, input logic first_fld);
    return {12'h000, first_fld, 1'b0, src_code(hit)};
  endfunction

  // Decoded bit of one symbol pair: the first symbol (upper bit of the pair).
  function automatic logic pair_bit(input logic [1:0] pr);
    return pr[1];
  endfunction

  // Warning for one symbol pair: set when no transition inside the pair.
  function automatic logic pair_bad(input logic [1:0] pr);
    return ~(pr[1] ^ pr[0]);
  endfunction

endpackage

// File: rtl/vbi_biphase_dec.sv
module vbi_biphase_dec #(
  parameter int NB = 8
) (
  input  logic [2*NB-1:0] sym,
  output logic [NB-1:0]   dat,
  output logic [NB-1:0]   bad
);
  import vbi_pack_pkg::*;

  for (genvar n = 0; n < NB; n++) begin : g_pair
    assign dat[n] = pair_bit(sym[2*n+1 -: 2]);
    assign bad[n] = pair_bad(sym[2*n+1 -: 2]);
  end

endmodule

// File: rtl/vbi_line_ctl.sv
module vbi_line_ctl #(
  parameter int AW = 8,
  parameter int BW = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         fmt_sel,
  input  logic                         line_start,
  input  logic                         line_end,
  input  logic [2:0]                   line_hit,
  input  logic                         field_first,
  input  logic [AW-1:0]                base_addr,
  input  logic                         byte_vld,
  input  logic [BW-1:0]                byte_in,
  input  logic [2*BW-1:0]              sym_in,
  output vbi_pack_pkg::pack_fmt_e      fmt_q,
  output logic [AW-1:0]                base_q,
  output logic [15:0]                  hdr_q,
  output logic                         line_clr,
  output logic                         hdr_fire,
  output logic                         hold_set,
  output logic                         hold_use,
  output logic                         e_vld,
  output logic [BW-1:0]                e_byte,
  output logic [2*BW-1:0]              e_sym,
  output logic                         e_end
);
  import vbi_pack_pkg::*;

  logic            active;
  logic            hdr_pend;
  logic            hold_vld;
  logic [BW-1:0]   hold_byte;
  logic [2*BW-1:0] hold_sym;
  logic            acc_byte;

  assign line_clr = start & line_start;
  assign acc_byte = start & byte_vld & active & ~line_start;
  assign hdr_fire = hdr_pend;
  assign hold_set = acc_byte & hdr_pend;
  assign hold_use = hold_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      hdr_pend  <= 1'b0;
      fmt_q     <= FMT_PAIR;
      base_q    <= '0;
      hdr_q     <= '0;
      hold_vld  <= 1'b0;
      hold_byte <= '0;
      hold_sym  <= '0;
    end else begin
      if (line_clr) begin
        active   <= 1'b1;
        hdr_pend <= 1'b1;
        fmt_q    <= pack_fmt_e'(fmt_sel);
        base_q   <= base_addr;
        hdr_q    <= hdr_word(line_hit, field_first);
      end else begin
        hdr_pend <= 1'b0;
        if (start & line_end) active <= 1'b0;
      end
      hold_vld <= hold_set;
      if (hold_set) begin
        hold_byte <= byte_in;
        hold_sym  <= sym_in;
      end
    end
  end

  always_comb begin
    e_vld  = hold_vld | (acc_byte & ~hdr_pend);
    e_byte = hold_vld ? hold_byte : byte_in;
    e_sym  = hold_vld ? hold_sym  : sym_in;
    e_end  = start & line_end & active & ~line_start;
  end

endmodule

// File: rtl/vbi_word_pack.sv
module vbi_word_pack #(
  parameter int BW         = 8,
  parameter int PAIR_WORDS = 21,
  parameter int BIPH_WORDS = 13,
  localparam int PAY_MAX   = (PAIR_WORDS > BIPH_WORDS) ? PAIR_WORDS : BIPH_WORDS,
  localparam int IW        = $clog2(PAY_MAX + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  vbi_pack_pkg::pack_fmt_e fmt_q,
  input  logic                    e_vld,
  input  logic [BW-1:0]           e_data,
  input  logic [BW-1:0]           e_warn,
  input  logic                    e_end,
  output logic                    pay_req,
  output logic [IW-1:0]           pay_idx,
  output logic [2*BW-1:0]         pay_word
);
  import vbi_pack_pkg::*;

  localparam logic [IW-1:0] LIM_PAIR = IW'(PAIR_WORDS);
  localparam logic [IW-1:0] LIM_BIPH = IW'(BIPH_WORDS);

  logic [IW-1:0] widx;
  logic          half;
  logic [BW-1:0] lo_byte;
  logic          room;
  logic          biph;

  assign biph    = (fmt_q == FMT_BIPH);
  assign room    = widx < (biph ? LIM_BIPH : LIM_PAIR);
  assign pay_idx = widx;

  always_comb begin
    pay_req  = 1'b0;
    pay_word = '0;
    if (e_vld) begin
      if (biph) begin
        pay_req  = room;
        pay_word = {e_warn, e_data};
      end else if (half) begin
        pay_req  = room;
        pay_word = {e_data, lo_byte};
      end
    end else if (e_end && !biph && half) begin
      pay_req  = room;
      pay_word = {{BW{1'b0}}, lo_byte};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      widx    <= '0;
      half    <= 1'b0;
      lo_byte <= '0;
    end else begin
      if (pay_req) widx <= widx + 1'b1;
      if (e_vld && !biph) begin
        half <= ~half;
        if (!half) lo_byte <= e_data;
      end else if (e_end) begin
        half <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vbi_wr_port.sv
module vbi_wr_port #(
  parameter int AW      = 8,
  parameter int IW      = 5,
  parameter int PAY_OFS = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          hdr_fire,
  input  logic [15:0]   hdr_q,
  input  logic [AW-1:0] base_q,
  input  logic          pay_req,
  input  logic [IW-1:0] pay_idx,
  input  logic [15:0]   pay_word,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data
);

  logic [AW-1:0] pay_addr;

  assign pay_addr = base_q + AW'(PAY_OFS) + AW'(pay_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= start & (hdr_fire | pay_req);
      if (hdr_fire) begin
        wr_addr <= base_q;
        wr_data <= hdr_q;
      end else if (pay_req) begin
        wr_addr <= pay_addr;
        wr_data <= pay_word;
      end
    end
  end

endmodule

// File: rtl/vbi_slice_packer.sv
module vbi_slice_packer #(
  parameter int AW         = 8,
  parameter int PAY_OFS    = 32,
  parameter int PAIR_WORDS = 21,
  parameter int BIPH_WORDS = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          fmt_sel,
  input  logic          line_start,
  input  logic          line_end,
  input  logic [2:0]    line_hit,
  input  logic          field_first,
  input  logic [AW-1:0] base_addr,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  input  logic [15:0]   sym_in,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data
);
  import vbi_pack_pkg::*;

  localparam int BW      = 8;
  localparam int PAY_MAX = (PAIR_WORDS > BIPH_WORDS) ? PAIR_WORDS : BIPH_WORDS;
  localparam int IW      = $clog2(PAY_MAX + 1);

  pack_fmt_e       fmt_q;
  logic [AW-1:0]   base_q;
  logic [15:0]     hdr_q;
  logic            line_clr;
  logic            hdr_fire;
  logic            hold_set;
  logic            hold_use;
  logic            e_vld;
  logic [BW-1:0]   e_byte;
  logic [2*BW-1:0] e_sym;
  logic            e_end;
  logic [BW-1:0]   dec_dat;
  logic [BW-1:0]   dec_bad;
  logic [BW-1:0]   e_data;
  logic [BW-1:0]   e_warn;
  logic            pay_fire;
  logic [IW-1:0]   pay_idx;
  logic [15:0]     pay_word;

  vbi_line_ctl #(.AW(AW), .BW(BW)) u_ctl (
    .clk(clk), .rst(rst), .start(start), .fmt_sel(fmt_sel),
    .line_start(line_start), .line_end(line_end), .line_hit(line_hit),
    .field_first(field_first), .base_addr(base_addr), .byte_vld(byte_vld),
    .byte_in(byte_in), .sym_in(sym_in), .fmt_q(fmt_q), .base_q(base_q),
    .hdr_q(hdr_q), .line_clr(line_clr), .hdr_fire(hdr_fire),
    .hold_set(hold_set), .hold_use(hold_use), .e_vld(e_vld),
    .e_byte(e_byte), .e_sym(e_sym), .e_end(e_end)
  );

  vbi_biphase_dec #(.NB(BW)) u_dec (
    .sym(e_sym), .dat(dec_dat), .bad(dec_bad)
  );

  assign e_data = (fmt_q == FMT_BIPH) ? dec_dat : e_byte;
  assign e_warn = (fmt_q == FMT_BIPH) ? dec_bad : '0;

  vbi_word_pack #(.BW(BW), .PAIR_WORDS(PAIR_WORDS), .BIPH_WORDS(BIPH_WORDS)) u_pack (
    .clk(clk), .rst(rst), .clr(line_clr), .fmt_q(fmt_q), .e_vld(e_vld),
    .e_data(e_data), .e_warn(e_warn), .e_end(e_end), .pay_req(pay_fire),
    .pay_idx(pay_idx), .pay_word(pay_word)
  );

  vbi_wr_port #(.AW(AW), .IW(IW), .PAY_OFS(PAY_OFS)) u_wr (
    .clk(clk), .rst(rst), .start(start), .hdr_fire(hdr_fire), .hdr_q(hdr_q),
    .base_q(base_q), .pay_req(pay_fire), .pay_idx(pay_idx),
    .pay_word(pay_word), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

endmodule

// File: rtl/vbi_slice_packer_chk.sv
module vbi_slice_packer_chk #(
  parameter int AW         = 8,
  parameter int PAY_OFS    = 32,
  parameter int PAIR_WORDS = 21,
  parameter int BIPH_WORDS = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [15:0]   wr_data,
  input logic          hdr_fire,
  input logic          pay_fire,
  input logic          hold_set,
  input logic          hold_use,
  input logic [AW-1:0] base_q,
  input logic          fmt_bit
);

  logic [AW-1:0] base_d;
  logic          fmt_d;
  logic [AW-1:0] rel;
  logic [AW-1:0] lim_hi;

  always_ff @(posedge clk) begin
    base_d <= base_q;
    fmt_d  <= fmt_bit;
  end

  assign rel    = wr_addr - base_d;
  assign lim_hi = AW'(PAY_OFS) + (fmt_d ? AW'(BIPH_WORDS) : AW'(PAIR_WORDS));

  // R1
  wr_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(start));

  // R7
  hdr_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(hdr_fire)) |-> (wr_addr == $past(base_q) && wr_data[15:4] == 12'h000 && !wr_data[2]));

  // R9
  pay_window_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(pay_fire)) |-> (rel >= AW'(PAY_OFS) && rel < lim_hi));

  // R11
  hold_next_chk: assert property (@(posedge clk) disable iff (rst)
    hold_set |=> hold_use);

  // R11
  one_write_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_fire |-> !pay_fire);

endmodule

bind vbi_slice_packer vbi_slice_packer_chk #(
  .AW(AW), .PAY_OFS(PAY_OFS), .PAIR_WORDS(PAIR_WORDS), .BIPH_WORDS(BIPH_WORDS)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .hdr_fire(hdr_fire), .pay_fire(pay_fire),
  .hold_set(hold_set), .hold_use(hold_use), .base_q(base_q),
  .fmt_bit(fmt_q == vbi_pack_pkg::FMT_BIPH)
);

// File: tb/vbi_slice_packer_test.sv
module vbi_slice_packer_test;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b1;
  logic          fmt_sel = 1'b0;
  logic          line_start = 1'b0;
  logic          line_end = 1'b0;
  logic [2:0]    line_hit = 3'b000;
  logic          field_first = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          byte_vld = 1'b0;
  logic [7:0]    byte_in = '0;
  logic [15:0]   sym_in = '0;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;

  vbi_slice_packer uut (
    .clk(clk), .rst(rst), .start(start), .fmt_sel(fmt_sel),
    .line_start(line_start), .line_end(line_end), .line_hit(line_hit),
    .field_first(field_first), .base_addr(base_addr), .byte_vld(byte_vld),
    .byte_in(byte_in), .sym_in(sym_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [15:0] mem [256];
  bit          wrt [256];
  int          wl_n;
  int          wl_addr [64];
  int          wl_cyc [64];
  logic [7:0]  bq [48];
  logic [15:0] sq [48];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && wr_en) begin
      mem[wr_addr] = wr_data;
      wrt[wr_addr] = 1'b1;
      if (wl_n < 64) begin
        wl_addr[wl_n] = int'(wr_addr);
        wl_cyc[wl_n]  = cyc;
      end
      wl_n = wl_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_dat(input logic [15:0] s);
    logic [7:0] d;
    for (int n = 0; n < 8; n++) d[n] = s[2*n+1];
    return d;
  endfunction

  function automatic logic [7:0] m_warn(input logic [15:0] s);
    logic [7:0] w;
    for (int n = 0; n < 8; n++) w[n] = (s[2*n+1] == s[2*n]);
    return w;
  endfunction

  function automatic logic [15:0] m_hdr(input logic [2:0] h, input logic f);
    logic [1:0] c;
    casez (h)
      3'b1??:  c = 2'd3;
      3'b01?:  c = 2'd2;
      3'b001:  c = 2'd1;
      default: c = 2'd0;
    endcase
    return {12'h000, f, 1'b0, c};
  endfunction

  task automatic clear_log();
    for (int i = 0; i < 256; i++) begin
      mem[i] = '0;
      wrt[i] = 1'b0;
    end
    wl_n = 0;
  endtask

  task automatic run_line(input logic [7:0] base, input bit fmt, input logic [2:0] hit,
                          input bit fld, input int n, input bit collide, input bit flip);
    logic [7:0]  a;
    logic [15:0] ew;
    int nw;
    int lim;
    clear_log();
    @(negedge clk);
    line_start = 1'b1; base_addr = base; fmt_sel = fmt; line_hit = hit; field_first = fld;
    @(negedge clk);
    line_start = 1'b0;
    if (flip) fmt_sel = ~fmt;
    if (!collide) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1; byte_in = bq[i]; sym_in = sq[i];
      @(negedge clk);
      byte_vld = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
    line_end = 1'b1;
    @(negedge clk);
    line_end = 1'b0;
    repeat (3) @(negedge clk);
    if (start) begin
      // R6 R7 header word at the head address
      chk(wrt[base] && mem[base] == m_hdr(hit, fld), "R6/R7 header", int'(mem[base]), int'(m_hdr(hit, fld)));
      a = base + 8'd1;
      chk(!wrt[a], "R8 gap below payload", int'(wrt[a]), 0);
      lim = fmt ? 13 : 21;
      nw  = fmt ? n : (n + 1) / 2;
      if (nw > lim) nw = lim;
      for (int k = 0; k < nw; k++) begin
        a = base + 8'h20 + 8'(k);
        if (fmt) ew = {m_warn(sq[k]), m_dat(sq[k])};
        else ew = {(2*k+1 < n) ? bq[2*k+1] : 8'h00, bq[2*k]};
        chk(wrt[a] && mem[a] == ew, fmt ? "R4/R5/R8/R10 biphase word" : "R2/R3/R8/R10 pair word",
            int'(mem[a]), int'(ew));
      end
      a = base + 8'h20 + 8'(nw);
      chk(!wrt[a], "R9 word past payload unwritten", int'(wrt[a]), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    clear_log();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk(wr_en == 1'b0, "R12 wr_en after reset", int'(wr_en), 0);
    chk(wr_addr == '0, "R12 wr_addr after reset", int'(wr_addr), 0);

    // R2 R3 odd-length pair line
    for (int i = 0; i < 48; i++) begin bq[i] = 8'($urandom); sq[i] = 16'($urandom); end
    run_line(8'h00, 1'b0, 3'b100, 1'b1, 5, 1'b0, 1'b0);
    // R9 pair line exactly at limit and beyond it
    run_line(8'h40, 1'b0, 3'b010, 1'b0, 42, 1'b0, 1'b0);
    run_line(8'h80, 1'b0, 3'b001, 1'b1, 47, 1'b0, 1'b0);
    // R5 all-valid and all-invalid pairs
    for (int i = 0; i < 48; i++) sq[i] = (i % 2 == 0) ? 16'h9669 : 16'hF00F;
    run_line(8'hC0, 1'b1, 3'b000, 1'b0, 6, 1'b0, 1'b0);
    // R9 bi-phase over limit
    for (int i = 0; i < 48; i++) sq[i] = 16'($urandom);
    run_line(8'h00, 1'b1, 3'b111, 1'b1, 20, 1'b0, 1'b0);
    // R10 fmt flips mid-line
    run_line(8'h40, 1'b1, 3'b011, 1'b0, 4, 1'b0, 1'b1);
    run_line(8'h80, 1'b0, 3'b101, 1'b1, 6, 1'b0, 1'b1);
    // R11 byte collides with header write
    run_line(8'hC0, 1'b1, 3'b010, 1'b1, 3, 1'b1, 1'b0);
    chk(wl_addr[0] == 32'hC0 && wl_addr[1] == 32'hE0, "R11 header then held byte", wl_addr[1], 32'hE0);
    chk(wl_cyc[1] - wl_cyc[0] == 1, "R11 held byte one cycle after header", wl_cyc[1] - wl_cyc[0], 1);
    // R1 start low: nothing stored
    start = 1'b0;
    run_line(8'h40, 1'b0, 3'b100, 1'b1, 8, 1'b0, 1'b0);
    chk(wl_n == 0, "R1 no writes with start low", wl_n, 0);
    start = 1'b1;
    // random lines
    for (int r = 0; r < 10; r++) begin
      for (int i = 0; i < 48; i++) begin bq[i] = 8'($urandom); sq[i] = 16'($urandom); end
      run_line(8'($urandom_range(0, 3) * 64), 1'($urandom), 3'($urandom), 1'($urandom),
               int'($urandom_range(0, 46)), 1'b0, 1'b0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule